// File: doc/BRIEF.md
# Operating Mode and Clock Controller

This block follows the processor through its five operating modes (reset, run, halt, sleep and debug) and turns the current mode and the software-chosen system clock source into a level enable for each of four oscillators. It takes single-cycle event pulses from the core, such as halt, sleep, debug entry and debug return, together with a wake-up line from the interrupt logic. It also tells the core when to stall.

A two-bit selection picks the system clock source. The core can load it only while running, and the new value applies from the next edge. In halt and debug only the selected source runs. In sleep each oscillator follows its own stop bit, and the selected source gets no special treatment. A debug entry saves the interrupted mode. A wake-up that arrives while debug is active is held, so leaving debug resumes run instead of the idle state.

Top module: `opmode_clk_ctrl`

## Requirements
- R1: While rst_ni is low, or on the edge after rst_req_i is sampled high, mode_o is RESET. The mode_o codes are RESET=0, RUN=1, HALT=2, SLEEP=3 and DEBUG=4. In RESET, sys_src_o is 0 and osc_en_o is 4'b0001 (internal only).
- R2: RESET moves to RUN on the edge where boot_done_i is high and rst_req_i is low. Until then it stays in RESET. The system source after boot is 0.
- R3: In RUN, halt_i moves the block to HALT on the next edge. The selected source stays enabled.
- R4: In RUN, sleep_i moves the block to SLEEP. While in SLEEP, osc_en_o[i] is the inverse of sleep_stop_i[i] for every source, whatever the selection.
- R5: In HALT or SLEEP, wake_i returns the block to RUN with sys_src_o unchanged. In RUN, wake_i has no effect.
- R6: In RUN, src_we_i loads src_sel_i into sys_src_o on the next edge. The codes are 0 internal, 1 low-speed, 2 high-speed and 3 external. The load has no effect in any other mode.
- R7: In RUN, HALT and DEBUG, osc_en_o has exactly the bit at index sys_src_o set.
- R8: In RUN, HALT or SLEEP, dbg_irq_i moves the block to DEBUG. In DEBUG, dbg_ret_i returns the block to the mode that debug interrupted. There is one exception: if that mode was HALT or SLEEP and wake_i was high on the entry cycle or at any cycle in DEBUG up to and including the return, the block returns to RUN.
- R9: stall_o is high in RESET, HALT and SLEEP, and low in RUN and DEBUG.
- R10: When requests coincide, the priority from highest to lowest is rst_req_i, dbg_irq_i, sleep_i, halt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Synchronous reset request (level) |
| boot_done_i | input | 1 | Boot sequence finished |
| halt_i | input | 1 | Halt instruction pulse |
| sleep_i | input | 1 | Sleep instruction pulse |
| dbg_irq_i | input | 1 | Debug interrupt pulse |
| dbg_ret_i | input | 1 | Return-from-debug pulse |
| wake_i | input | 1 | Halt/sleep cancelation |
| src_we_i | input | 1 | Source selection write strobe |
| src_sel_i | input | 2 | Source selection write data |
| sleep_stop_i | input | 4 | Per-source stop-in-sleep bits (1 = stop) |
| mode_o | output | 3 | Current operating mode |
| osc_en_o | output | 4 | Per-oscillator enables |
| sys_src_o | output | 2 | Applied system clock source index |
| stall_o | output | 1 | Core stall |

## Verification
The properties assume that the event pulses reach the block as clean, synchronous levels. They also assume that sleep_stop_i is stable across the cycle in which enables are compared, and that rst_req_i explains every forced return to RESET, so each transition property excludes cycles with a reset request. The stimulus applies every input on the falling edge and holds it for one full cycle. It raises coinciding requests only in the cycles meant to test priority, and it changes the stop mask only while the block sits in SLEEP.

// File: rtl/opmode_clk_pkg.sv
package opmode_clk_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RESET = 3'd0,
    MODE_RUN   = 3'd1,
    MODE_HALT  = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_DEBUG = 3'd4
  } op_mode_e;

  function automatic logic mode_is_idle(op_mode_e m);
    return (m == MODE_HALT) || (m == MODE_SLEEP);
  endfunction

  function automatic logic mode_stalls(op_mode_e m);
    return (m == MODE_RESET) || mode_is_idle(m);
  endfunction

endpackage

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rst_req_i,
  input  logic     boot_done_i,
  input  logic     halt_i,
  input  logic     sleep_i,
  input  logic     dbg_irq_i,
  input  logic     dbg_ret_i,
  input  logic     wake_i,
  output op_mode_e mode_o
);

  op_mode_e mode_q, mode_d;
  op_mode_e saved_q, saved_d;
  logic     pend_q, pend_d;

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    pend_d  = pend_q;
    if (rst_req_i) begin
      mode_d  = MODE_RESET;
      saved_d = MODE_RUN;
      pend_d  = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_RESET: begin
          if (boot_done_i) mode_d = MODE_RUN;
        end
        MODE_RUN: begin
          if (dbg_irq_i) begin
            mode_d  = MODE_DEBUG;
            saved_d = MODE_RUN;
            pend_d  = 1'b0;
          end else if (sleep_i) begin
            mode_d = MODE_SLEEP;
          end else if (halt_i) begin
            mode_d = MODE_HALT;
          end
        end
        MODE_HALT, MODE_SLEEP: begin
          if (dbg_irq_i) begin
            mode_d  = MODE_DEBUG;
            saved_d = mode_q;
            pend_d  = wake_i;          // wake racing the debug entry is kept
          end else if (wake_i) begin
            mode_d = MODE_RUN;
          end
        end
        MODE_DEBUG: begin
          if (dbg_ret_i) begin
            mode_d = ((pend_q || wake_i) && mode_is_idle(saved_q)) ? MODE_RUN : saved_q;
            pend_d = 1'b0;
          end else begin
            pend_d = pend_q || wake_i;
          end
        end
        default: mode_d = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RESET;
      saved_q <= MODE_RUN;
      pend_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
      pend_q  <= pend_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/clksel_reg.sv
module clksel_reg #(
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned BOOT_SRC = 0,
  localparam int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_req_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [SEL_W-1:0] BOOT_IDX = SEL_W'(BOOT_SRC);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= BOOT_IDX;
    else if (rst_req_i) sel_q <= BOOT_IDX;
    else if (load_i)    sel_q <= sel_i;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/osc_gate.sv
module osc_gate
  import opmode_clk_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned BOOT_SRC = 0,
  localparam int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  op_mode_e         mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NUM_SRC-1:0] stop_i,
  output logic [NUM_SRC-1:0] en_o
);

  logic in_reset, in_sleep;
  assign in_reset = (mode_i == MODE_RESET);
  assign in_sleep = (mode_i == MODE_SLEEP);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    localparam logic IS_BOOT = (g == BOOT_SRC);
    assign en_o[g] = in_reset ? IS_BOOT :
                     in_sleep ? ~stop_i[g] :
                                (sel_i == IDX);
  end

endmodule

// File: rtl/opmode_clk_ctrl.sv
module opmode_clk_ctrl
  import opmode_clk_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 4,
  parameter int unsigned BOOT_SRC = 0,
  localparam int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_req_i,
  input  logic               boot_done_i,
  input  logic               halt_i,
  input  logic               sleep_i,
  input  logic               dbg_irq_i,
  input  logic               dbg_ret_i,
  input  logic               wake_i,
  input  logic               src_we_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [NUM_SRC-1:0] sleep_stop_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic [NUM_SRC-1:0] osc_en_o,
  output logic [SEL_W-1:0]   sys_src_o,
  output logic               stall_o
);

  op_mode_e         mode;
  logic [SEL_W-1:0] sel;
  logic             sel_load;

  opmode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_req_i  (rst_req_i),
    .boot_done_i(boot_done_i),
    .halt_i     (halt_i),
    .sleep_i    (sleep_i),
    .dbg_irq_i  (dbg_irq_i),
    .dbg_ret_i  (dbg_ret_i),
    .wake_i     (wake_i),
    .mode_o     (mode)
  );

  // source changes only while running
  assign sel_load = src_we_i && (mode == MODE_RUN);

  clksel_reg #(.NUM_SRC(NUM_SRC), .BOOT_SRC(BOOT_SRC)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_req_i(rst_req_i),
    .load_i   (sel_load),
    .sel_i    (src_sel_i),
    .sel_o    (sel)
  );

  osc_gate #(.NUM_SRC(NUM_SRC), .BOOT_SRC(BOOT_SRC)) u_gate (
    .mode_i(mode),
    .sel_i (sel),
    .stop_i(sleep_stop_i),
    .en_o  (osc_en_o)
  );

  assign mode_o    = mode;
  assign sys_src_o = sel;
  assign stall_o   = mode_stalls(mode);

endmodule

// File: rtl/opmode_clk_ctrl_chk.sv
module opmode_clk_ctrl_chk #(
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_req_i,
  input logic               boot_done_i,
  input logic               halt_i,
  input logic               sleep_i,
  input logic               dbg_irq_i,
  input logic               wake_i,
  input logic [NUM_SRC-1:0] sleep_stop_i,
  input logic [2:0]         mode_o,
  input logic [NUM_SRC-1:0] osc_en_o,
  input logic [SEL_W-1:0]   sys_src_o,
  input logic               stall_o
);

  localparam logic [2:0] M_RESET = 3'd0;
  localparam logic [2:0] M_RUN   = 3'd1;
  localparam logic [2:0] M_HALT  = 3'd2;
  localparam logic [2:0] M_SLEEP = 3'd3;
  localparam logic [2:0] M_DEBUG = 3'd4;

  // R1
  reset_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (mode_o == M_RESET));

  // R2
  boot_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_RESET && boot_done_i && !rst_req_i) |=> (mode_o == M_RUN));

  // R3
  halt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_RUN && halt_i && !sleep_i && !dbg_irq_i && !rst_req_i) |=> (mode_o == M_HALT));

  // R4
  sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_SLEEP) |-> (osc_en_o == ~sleep_stop_i));

  // R5
  wake_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_HALT || mode_o == M_SLEEP) && wake_i && !dbg_irq_i && !rst_req_i)
    |=> (mode_o == M_RUN && $stable(sys_src_o)));

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != M_RUN && !rst_req_i) |=> $stable(sys_src_o));

  // R7
  single_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_HALT || mode_o == M_DEBUG) |-> ($countones(osc_en_o) == 1 && osc_en_o[sys_src_o]));

  // R8
  debug_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_RUN || mode_o == M_HALT || mode_o == M_SLEEP) && dbg_irq_i && !rst_req_i)
    |=> (mode_o == M_DEBUG));

  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o == (mode_o == M_RESET || mode_o == M_HALT || mode_o == M_SLEEP));

  // R10
  sleep_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_RUN && halt_i && sleep_i && !dbg_irq_i && !rst_req_i) |=> (mode_o == M_SLEEP));

endmodule

bind opmode_clk_ctrl opmode_clk_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_req_i   (rst_req_i),
  .boot_done_i (boot_done_i),
  .halt_i      (halt_i),
  .sleep_i     (sleep_i),
  .dbg_irq_i   (dbg_irq_i),
  .wake_i      (wake_i),
  .sleep_stop_i(sleep_stop_i),
  .mode_o      (mode_o),
  .osc_en_o    (osc_en_o),
  .sys_src_o   (sys_src_o),
  .stall_o     (stall_o)
);

// File: tb/opmode_clk_ctrl_bench.sv
module opmode_clk_ctrl_bench;

  localparam int NUM_SRC = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_req_i = 1'b1, boot_done_i = 1'b0;
  logic       halt_i = 1'b0, sleep_i = 1'b0, dbg_irq_i = 1'b0, dbg_ret_i = 1'b0, wake_i = 1'b0;
  logic       src_we_i = 1'b0;
  logic [1:0] src_sel_i = '0;
  logic [3:0] sleep_stop_i = 4'b1110;
  logic [2:0] mode_o;
  logic [3:0] osc_en_o;
  logic [1:0] sys_src_o;
  logic       stall_o;

  // staged levels, applied by the driver at its falling edge
  logic       rq_v = 1'b1, bd_v = 1'b0;
  logic [3:0] stop_v = 4'b1110;

  always #10 clk_i = ~clk_i;  // 50 MHz

  opmode_clk_ctrl u_opmode_clk_ctrl (
    .clk_i, .rst_ni, .rst_req_i, .boot_done_i, .halt_i, .sleep_i,
    .dbg_irq_i, .dbg_ret_i, .wake_i, .src_we_i, .src_sel_i, .sleep_stop_i,
    .mode_o, .osc_en_o, .sys_src_o, .stall_o
  );

  typedef struct packed {
    logic [2:0] m;
    logic [1:0] s;
    logic [3:0] en;
    logic       st;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;

  function automatic obs_t model(logic [2:0] m, logic [1:0] s, logic [3:0] stop);
    obs_t o;
    o.m  = m;
    o.s  = s;
    o.en = (m == 3'd0) ? 4'b0001 : (m == 3'd3) ? ~stop : (4'b0001 << s);
    o.st = (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
    return o;
  endfunction

  task automatic compare(obs_t e, string tag);
    obs_t a;
    a = '{m: mode_o, s: sys_src_o, en: osc_en_o, st: stall_o};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: mode=%0d src=%0d en=%b stall=%b, expected mode=%0d src=%0d en=%b stall=%b",
               tag, a.m, a.s, a.en, a.st, e.m, e.s, e.en, e.st);
    end
  endtask

  // monitor: a quarter period after each rising edge
  initial forever begin
    @(posedge clk_i);
    #5;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic cyc(input logic h, input logic s, input logic d, input logic r,
                     input logic w, input logic we, input logic [1:0] sel,
                     input logic [2:0] em, input logic [1:0] es, input string tag);
    @(negedge clk_i);
    rst_req_i = rq_v; boot_done_i = bd_v; sleep_stop_i = stop_v;
    halt_i = h; sleep_i = s; dbg_irq_i = d; dbg_ret_i = r; wake_i = w;
    src_we_i = we; src_sel_i = sel;
    exp_q.push_back(model(em, es, stop_v));
    tag_q.push_back(tag);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    compare(model(3'd0, 2'd0, 4'b1110), "R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    //  h  s  d  r  w  we sel    mode  src
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0, "R1 request held");
    rq_v = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0, "R2 wait for boot");
    bd_v = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 3'd1, 2'd0, "R2 boot to run");
    cyc(0, 0, 0, 0, 0, 1, 2'd2, 3'd1, 2'd2, "R6 R7 select high-speed");
    cyc(1, 0, 0, 0, 0, 0, 2'd0, 3'd2, 2'd2, "R3 R9 halt");
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 3'd2, 2'd2, "R6 write in halt ignored");
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 3'd1, 2'd2, "R5 wake from halt");
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 3'd1, 2'd2, "R5 wake in run ignored");
    cyc(0, 1, 0, 0, 0, 0, 2'd0, 3'd3, 2'd2, "R4 sleep keeps internal");
    stop_v = 4'b0011;
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 3'd3, 2'd2, "R4 sleep stop mask");
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 3'd1, 2'd2, "R5 wake from sleep");
    cyc(1, 1, 0, 0, 0, 0, 2'd0, 3'd3, 2'd2, "R10 sleep over halt");
    cyc(0, 0, 1, 0, 0, 0, 2'd0, 3'd4, 2'd2, "R8 debug from sleep");
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 3'd4, 2'd2, "R6 write in debug ignored");
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 3'd4, 2'd2, "R8 wake held in debug");
    cyc(0, 0, 0, 1, 0, 0, 2'd0, 3'd1, 2'd2, "R8 return with held wake");
    cyc(1, 0, 0, 0, 0, 0, 2'd0, 3'd2, 2'd2, "R3 halt again");
    cyc(0, 0, 1, 0, 0, 0, 2'd0, 3'd4, 2'd2, "R8 debug from halt");
    cyc(0, 0, 0, 1, 0, 0, 2'd0, 3'd2, 2'd2, "R8 return to halt");
    cyc(0, 0, 0, 0, 1, 0, 2'd0, 3'd1, 2'd2, "R5 wake");
    cyc(1, 1, 1, 0, 0, 0, 2'd0, 3'd4, 2'd2, "R10 debug over sleep and halt");
    cyc(0, 0, 0, 1, 0, 0, 2'd0, 3'd1, 2'd2, "R8 return to run");
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 3'd1, 2'd3, "R7 external source");
    rq_v = 1'b1;
    cyc(0, 0, 1, 0, 0, 0, 2'd0, 3'd0, 2'd0, "R10 R1 reset over debug");
    rq_v = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 2'd0, 3'd1, 2'd0, "R2 reboot on internal");
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 3'd1, 2'd1, "R6 select low-speed");
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule